// File: doc/BRIEF.md
# Three-Phase Synchronous-Frame Phase Tracker

This block estimates the angle of a balanced or mildly disturbed three-phase voltage set in fixed point. On every sample strobe it takes three signed phase samples and reduces them to a two-axis stationary vector. It then rotates that vector by the current angle estimate to obtain a direct-axis error, which is proportional to the sine of the angle mismatch. A proportional-integral regulator turns the negated error into a frequency correction. That correction is added to a nominal frequency word and accumulated modulo 2^W_PH into the angle estimate. The new angle addresses a quarter-wave sine table, and the table yields the sine and cosine unit vectors. Those unit vectors are held in registers and are also the ones used by the next rotation.

The gains and the integrator limits are plain inputs. A symmetric-optimum design derives the gains from a single spread factor and the sample period: a larger spread factor gives a narrower loop bandwidth and more phase margin. The loop locks when the direct-axis error is driven to zero.

Top module: `srf_pll`

## Requirements
- R1: While `rst` is high at a clock edge, the following hold after that edge: `phase_o`, `freq_o` and `derr_o` are 0, the integrator is 0, and `sin_o`/`cos_o` hold the table values for the first angle bin (101 and 32767 at default widths).
- R2: Stationary components are alpha = ((2·a − b − c)·21845) >>> 16 and beta = ((b − c)·37837) >>> 16, computed on the signed phase samples with arithmetic shifts.
- R3: On a strobe, `derr_o` becomes (alpha·cos_o + beta·sin_o) >>> (W_U−1), using the unit vectors held before that strobe.
- R4: On a strobe, with e = −derr, the integrator becomes integ + gain_i·e, clamped first to `integ_hi` (if above) and then to `integ_lo` (if below).
- R5: On a strobe, `freq_o` becomes (freq_nom + ((gain_p·e + new integrator) >>> GAIN_FRAC)) mod 2^W_PH.
- R6: On a strobe, `phase_o` advances by the new `freq_o` modulo 2^W_PH and wraps through zero.
- R7: After a strobe, with k the top LUT_AW+2 bits of the new `phase_o`, `sin_o`/`cos_o` equal sin/cos((k+0.5)·2π/2^(LUT_AW+2)) scaled by 2^(W_U−1)−1 and rounded on magnitude. Hence `sin_o` is negative exactly when the phase MSB is set, and `cos_o` is negative exactly when the top two phase bits are 01 or 10.
- R8: A clock edge without `smp_vld` leaves every output and the integrator unchanged.
- R9: With gain_p=16384, gain_i=256 and a balanced input of amplitude 10000 rotating 800 units per sample faster than `freq_nom`, the loop settles: |derr_o| ≤ 300 and `phase_o` lies within 2^W_PH/128 of the input's next angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; advances the loop once |
| phase_a | input | W_IN | Signed sample, phase A |
| phase_b | input | W_IN | Signed sample, phase B |
| phase_c | input | W_IN | Signed sample, phase C |
| freq_nom | input | W_PH | Nominal phase increment per sample |
| gain_p | input | W_G | Signed proportional gain |
| gain_i | input | W_G | Signed integral gain |
| integ_hi | input | W_I | Signed upper integrator limit |
| integ_lo | input | W_I | Signed lower integrator limit |
| derr_o | output | W_IN+2 | Signed direct-axis error |
| freq_o | output | W_PH | Phase increment applied on the last strobe |
| phase_o | output | W_PH | Angle estimate, unsigned modulo 2^W_PH |
| sin_o | output | W_U | Signed sine unit vector |
| cos_o | output | W_U | Signed cosine unit vector |

## Verification
The integrator clamp and the accumulator wrap can fall on the same strobe. In that case the clamped integrator value feeds the increment that carries the phase through zero. The bench provokes this coincidence with tight integrator limits, a maximal integral gain and a nominal increment near 15/16 of a turn, so the phase wraps on almost every strobe while the integrator stays pinned. Every strobe is judged against an exact bench model of phase, increment, error and unit vectors, and against a bound on the increment set by the limits.

// File: rtl/srf_pll_pkg.sv
package srf_pll_pkg;

  localparam int     CLARKE_FRAC = 16;
  localparam longint K_THIRD     = ((longint'(1) << CLARKE_FRAC) + 1) / 3;
  localparam longint K_INV_RT3   = 37837;  // round(2^16 / sqrt(3))

  function automatic longint clarke_alpha(longint a, longint b, longint c);
    return ((2 * a - b - c) * K_THIRD) >>> CLARKE_FRAC;
  endfunction

  function automatic longint clarke_beta(longint b, longint c);
    return ((b - c) * K_INV_RT3) >>> CLARKE_FRAC;
  endfunction

  function automatic longint rotate_d(longint al, longint be, longint s, longint c, int frac);
    return (al * c + be * s) >>> frac;
  endfunction

  function automatic longint clip(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // magnitude of one quarter-wave entry, sampled at bin centres
  function automatic int quarter_mag(int idx, int aw, int amp);
    real ang;
    ang = (real'(idx) + 0.5) * 3.141592653589793 / (2.0 * real'(1 << aw));
    return $rtoi($sin(ang) * real'(amp) + 0.5);
  endfunction

endpackage

// File: rtl/srf_frame.sv
module srf_frame
  import srf_pll_pkg::*;
#(
  parameter int W_IN = 16,
  parameter int W_U  = 16,
  parameter int W_D  = 18
)(
  input  logic signed [W_IN-1:0] smp_a,
  input  logic signed [W_IN-1:0] smp_b,
  input  logic signed [W_IN-1:0] smp_c,
  input  logic signed [W_U-1:0]  unit_s,
  input  logic signed [W_U-1:0]  unit_c,
  output logic signed [W_D-1:0]  d_err
);
  longint alpha_v, beta_v;

  always_comb begin
    alpha_v = clarke_alpha(longint'(smp_a), longint'(smp_b), longint'(smp_c));
    beta_v  = clarke_beta(longint'(smp_b), longint'(smp_c));
    d_err   = W_D'(rotate_d(alpha_v, beta_v, longint'(unit_s), longint'(unit_c), W_U - 1));
  end
endmodule

// File: rtl/srf_pi.sv
module srf_pi
  import srf_pll_pkg::*;
#(
  parameter int W_D       = 18,
  parameter int W_G       = 16,
  parameter int W_I       = 40,
  parameter int W_PH      = 24,
  parameter int GAIN_FRAC = 8
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [W_D-1:0]  d_err,
  input  logic signed [W_G-1:0]  kp,
  input  logic signed [W_G-1:0]  ki,
  input  logic signed [W_I-1:0]  lim_hi,
  input  logic signed [W_I-1:0]  lim_lo,
  output logic signed [W_I-1:0]  integ_q,
  output logic [W_PH-1:0]        step,
  output logic                   clamped
);
  longint neg_err, raw_sum, held_sum;

  always_comb begin
    neg_err  = -longint'(d_err);
    raw_sum  = longint'(integ_q) + longint'(ki) * neg_err;
    held_sum = clip(raw_sum, longint'(lim_lo), longint'(lim_hi));
    clamped  = (held_sum != raw_sum);
    step     = W_PH'((longint'(kp) * neg_err + held_sum) >>> GAIN_FRAC);
  end

  always_ff @(posedge clk) begin
    if (rst)     integ_q <= '0;
    else if (en) integ_q <= W_I'(held_sum);
  end
endmodule

// File: rtl/srf_nco.sv
module srf_nco
  import srf_pll_pkg::*;
#(
  parameter int W_PH   = 24,
  parameter int W_U    = 16,
  parameter int LUT_AW = 8
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [W_PH-1:0]        f_nom,
  input  logic [W_PH-1:0]        step,
  output logic [W_PH-1:0]        phase_q,
  output logic [W_PH-1:0]        freq_q,
  output logic signed [W_U-1:0]  sin_q,
  output logic signed [W_U-1:0]  cos_q,
  output logic                   wrap
);
  localparam int TN  = 1 << LUT_AW;
  localparam int AMP = (1 << (W_U - 1)) - 1;
  localparam int KW  = LUT_AW + 2;

  logic [W_U-1:0] qtab [TN];

  for (genvar g = 0; g < TN; g++) begin : g_qtab
    assign qtab[g] = W_U'(quarter_mag(g, LUT_AW, AMP));
  end

  logic [W_PH-1:0]          freq_next, phase_next;
  logic [KW-1:0]            bin;
  logic [1:0]               q_s, q_c;
  logic [LUT_AW-1:0]        idx;
  logic [W_U-1:0]           mag_s, mag_c;
  logic signed [W_U-1:0]    s_next, c_next, s_rst, c_rst;

  always_comb begin
    freq_next           = f_nom + step;
    {wrap, phase_next}  = {1'b0, phase_q} + {1'b0, freq_next};
    bin                 = phase_next[W_PH-1 -: KW];
    q_s                 = bin[KW-1 -: 2];
    idx                 = bin[LUT_AW-1:0];
    q_c                 = q_s + 2'd1;
    mag_s               = q_s[0] ? qtab[~idx] : qtab[idx];
    mag_c               = q_c[0] ? qtab[~idx] : qtab[idx];
    s_next              = q_s[1] ? -$signed(mag_s) : $signed(mag_s);
    c_next              = q_c[1] ? -$signed(mag_c) : $signed(mag_c);
    s_rst               = $signed(qtab[0]);
    c_rst               = $signed(qtab[TN-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      freq_q  <= '0;
      sin_q   <= s_rst;
      cos_q   <= c_rst;
    end else if (en) begin
      phase_q <= phase_next;
      freq_q  <= freq_next;
      sin_q   <= s_next;
      cos_q   <= c_next;
    end
  end
endmodule

// File: rtl/srf_pll.sv
module srf_pll #(
  parameter int W_IN      = 16,
  parameter int W_U       = 16,
  parameter int W_PH      = 24,
  parameter int W_G       = 16,
  parameter int W_I       = 40,
  parameter int LUT_AW    = 8,
  parameter int GAIN_FRAC = 8,
  localparam int W_D      = W_IN + 2
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_vld,
  input  logic signed [W_IN-1:0] phase_a,
  input  logic signed [W_IN-1:0] phase_b,
  input  logic signed [W_IN-1:0] phase_c,
  input  logic [W_PH-1:0]        freq_nom,
  input  logic signed [W_G-1:0]  gain_p,
  input  logic signed [W_G-1:0]  gain_i,
  input  logic signed [W_I-1:0]  integ_hi,
  input  logic signed [W_I-1:0]  integ_lo,
  output logic signed [W_D-1:0]  derr_o,
  output logic [W_PH-1:0]        freq_o,
  output logic [W_PH-1:0]        phase_o,
  output logic signed [W_U-1:0]  sin_o,
  output logic signed [W_U-1:0]  cos_o
);
  logic signed [W_D-1:0] derr_c;
  logic [W_PH-1:0]       step_c;
  logic signed [W_I-1:0] integ_val;
  logic                  int_clamped;
  logic                  acc_wrap;

  srf_frame #(.W_IN(W_IN), .W_U(W_U), .W_D(W_D)) u_frame (
    .smp_a(phase_a), .smp_b(phase_b), .smp_c(phase_c),
    .unit_s(sin_o), .unit_c(cos_o), .d_err(derr_c)
  );

  srf_pi #(.W_D(W_D), .W_G(W_G), .W_I(W_I), .W_PH(W_PH), .GAIN_FRAC(GAIN_FRAC)) u_pi (
    .clk(clk), .rst(rst), .en(smp_vld), .d_err(derr_c),
    .kp(gain_p), .ki(gain_i), .lim_hi(integ_hi), .lim_lo(integ_lo),
    .integ_q(integ_val), .step(step_c), .clamped(int_clamped)
  );

  srf_nco #(.W_PH(W_PH), .W_U(W_U), .LUT_AW(LUT_AW)) u_nco (
    .clk(clk), .rst(rst), .en(smp_vld), .f_nom(freq_nom), .step(step_c),
    .phase_q(phase_o), .freq_q(freq_o), .sin_q(sin_o), .cos_q(cos_o), .wrap(acc_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)          derr_o <= '0;
    else if (smp_vld) derr_o <= derr_c;
  end
endmodule

// File: rtl/srf_pll_chk.sv
module srf_pll_chk #(
  parameter int W_U  = 16,
  parameter int W_PH = 24,
  parameter int W_I  = 40,
  parameter int W_D  = 18
)(
  input logic                  clk,
  input logic                  rst,
  input logic                  smp_vld,
  input logic signed [W_I-1:0] integ_hi,
  input logic signed [W_I-1:0] integ_lo,
  input logic signed [W_I-1:0] integ_val,
  input logic                  int_clamped,
  input logic                  acc_wrap,
  input logic signed [W_D-1:0] derr_o,
  input logic [W_PH-1:0]       freq_o,
  input logic [W_PH-1:0]       phase_o,
  input logic signed [W_U-1:0] sin_o,
  input logic signed [W_U-1:0] cos_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (phase_o == '0 && freq_o == '0 && derr_o == '0 && integ_val == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(phase_o) && $stable(freq_o) && $stable(derr_o)
                  && $stable(sin_o) && $stable(cos_o) && $stable(integ_val)));

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (phase_o == $past(phase_o) + freq_o));

  // R6
  wrap_through_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && acc_wrap) |=> (phase_o < $past(phase_o)));

  // R4
  clamp_to_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && int_clamped) |=> (integ_val == $past(integ_hi) || integ_val == $past(integ_lo)));

  // R4
  integ_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && integ_lo <= integ_hi) |=> (integ_val <= $past(integ_hi) && integ_val >= $past(integ_lo)));

  // R7
  sin_sign_chk: assert property (@(posedge clk) disable iff (rst)
    sin_o[W_U-1] == phase_o[W_PH-1]);

  // R7
  cos_sign_chk: assert property (@(posedge clk) disable iff (rst)
    cos_o[W_U-1] == (phase_o[W_PH-1] ^ phase_o[W_PH-2]));
endmodule

bind srf_pll srf_pll_chk #(.W_U(W_U), .W_PH(W_PH), .W_I(W_I), .W_D(W_D)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .integ_hi(integ_hi), .integ_lo(integ_lo),
  .integ_val(integ_val), .int_clamped(int_clamped), .acc_wrap(acc_wrap),
  .derr_o(derr_o), .freq_o(freq_o), .phase_o(phase_o), .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/srf_pll_bench.sv
module srf_pll_bench;
  localparam longint MASK = 64'hFF_FFFF;
  localparam real    PI2  = 6.283185307179586;

  logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b0;
  logic signed [15:0] phase_a = '0, phase_b = '0, phase_c = '0;
  logic [23:0]        freq_nom = '0;
  logic signed [15:0] gain_p = '0, gain_i = '0;
  logic signed [39:0] integ_hi = '0, integ_lo = '0;
  logic signed [17:0] derr_o;
  logic [23:0]        freq_o, phase_o;
  logic signed [15:0] sin_o, cos_o;

  srf_pll u_srf_pll (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .phase_a(phase_a), .phase_b(phase_b), .phase_c(phase_c),
    .freq_nom(freq_nom), .gain_p(gain_p), .gain_i(gain_i),
    .integ_hi(integ_hi), .integ_lo(integ_lo),
    .derr_o(derr_o), .freq_o(freq_o), .phase_o(phase_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  longint m_phase, m_freq, m_derr, m_integ, m_sin, m_cos;

  function automatic longint unit_ref(longint ph, bit want_cos);
    longint k; real a, v; longint mg;
    k  = ph >> 14;
    a  = (real'(k) + 0.5) * PI2 / 1024.0;
    v  = want_cos ? $cos(a) : $sin(a);
    mg = longint'($rtoi((v < 0.0 ? -v : v) * 32767.0 + 0.5));
    return (v < 0.0) ? -mg : mg;
  endfunction

  function automatic longint rnd(real x);
    return longint'($rtoi(x >= 0.0 ? x + 0.5 : x - 0.5));
  endfunction

  task automatic model_reset();
    m_phase = 0; m_freq = 0; m_derr = 0; m_integ = 0;
    m_sin = unit_ref(0, 1'b0); m_cos = unit_ref(0, 1'b1);
  endtask

  task automatic model_step();
    longint a, b, c, al, be, d, e, s, st;
    a = longint'(phase_a); b = longint'(phase_b); c = longint'(phase_c);
    al = ((a + a - b - c) * 21845) >>> 16;           // R2
    be = ((b - c) * 37837) >>> 16;
    d  = (al * m_cos + be * m_sin) >>> 15;           // R3
    e  = -d;
    s  = m_integ + longint'(gain_i) * e;             // R4
    if (s > longint'(integ_hi)) s = longint'(integ_hi);
    else if (s < longint'(integ_lo)) s = longint'(integ_lo);
    m_integ = s;
    st      = (longint'(gain_p) * e + s) >>> 8;      // R5
    m_freq  = (longint'(freq_nom) + st) & MASK;
    m_phase = (m_phase + m_freq) & MASK;             // R6
    m_derr  = d;
    m_sin   = unit_ref(m_phase, 1'b0);               // R7
    m_cos   = unit_ref(m_phase, 1'b1);
  endtask

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(bit strobed);
    if (strobed) begin
      check("R2 R3 derr", longint'(derr_o), m_derr);
      check("R5 freq", longint'(freq_o), m_freq);
      check("R6 phase", longint'(phase_o), m_phase);
      check("R7 sin", longint'(sin_o), m_sin);
      check("R7 cos", longint'(cos_o), m_cos);
    end else begin
      check("R8 hold phase", longint'(phase_o), m_phase);
      check("R8 hold derr", longint'(derr_o), m_derr);
      check("R8 hold unit", longint'(sin_o) * 65536 + longint'(cos_o), m_sin * 65536 + m_cos);
      check("R8 hold freq", longint'(freq_o), m_freq);
    end
  endtask

  // inputs are set by the caller at least 1 time unit after an edge
  task automatic tick(bit v);
    smp_vld = v;
    @(posedge clk); #1;
    if (v) model_step();
    compare_all(v);
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_vld = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    model_reset();
    check("R1 phase", longint'(phase_o), 0);
    check("R1 freq", longint'(freq_o), 0);
    check("R1 derr", longint'(derr_o), 0);
    check("R1 sin", longint'(sin_o), 101);
    check("R1 cos", longint'(cos_o), 32767);
  endtask

  task automatic set_balanced(longint ang, real vm);
    real th, al, be;
    th = real'(ang) * PI2 / 16777216.0;
    al = -vm * $sin(th);
    be =  vm * $cos(th);
    phase_a = 16'(rnd(al));
    phase_b = 16'(rnd(-al / 2.0 + 0.8660254037844386 * be));
    phase_c = 16'(rnd(-al / 2.0 - 0.8660254037844386 * be));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic signed [39:0] r1, r2;
    longint th_in, dmax, diff;
    void'($urandom(32'h5EED_0417));
    model_reset();
    do_reset();

    // random stimulus against the exact model
    for (int n = 0; n < 400; n++) begin
      phase_a  = 16'($urandom); phase_b = 16'($urandom); phase_c = 16'($urandom);
      freq_nom = 24'($urandom);
      gain_p   = 16'($urandom); gain_i = 16'($urandom);
      r1 = {8'($urandom), 32'($urandom)};
      r2 = {8'($urandom), 32'($urandom)};
      if (r1 > r2) begin integ_hi = r1; integ_lo = r2; end
      else         begin integ_hi = r2; integ_lo = r1; end
      tick(($urandom % 4) != 0);
    end

    // directed: sample strobe absent for several edges (R8)
    for (int n = 0; n < 5; n++) begin
      phase_a = 16'($urandom);
      tick(1'b0);
    end

    // directed: clamp pinned while the accumulator wraps (R4, R6)
    gain_p = '0; gain_i = 16'sd32767;
    integ_hi = 40'sd5000; integ_lo = -40'sd5000;
    freq_nom = 24'hF00000;
    for (int n = 0; n < 24; n++) begin
      phase_a = (n % 2 == 0) ? 16'sd20000 : -16'sd20000;
      phase_b = -16'sd10000; phase_c = 16'sd9000;
      tick(1'b1);
      diff = (longint'(freq_o) - longint'(freq_nom)) & MASK;
      if (diff >= 64'h80_0000) diff = diff - 64'h100_0000;
      check("R4 clamped increment bound", (diff >= -20 && diff <= 19) ? 1 : 0, 1);
    end

    // lock on a rotating balanced input with a frequency offset (R9)
    do_reset();
    gain_p = 16'sd16384; gain_i = 16'sd256;
    integ_hi = 40'sd1073741824; integ_lo = -40'sd1073741824;
    freq_nom = 24'd167772;
    th_in = 64'h40_0000;
    dmax = 0;
    for (int n = 0; n < 3000; n++) begin
      set_balanced(th_in, 10000.0);
      tick(1'b1);
      th_in = (th_in + 167772 + 800) & MASK;
      if (n >= 2800) begin
        diff = longint'(derr_o);
        if (diff < 0) diff = -diff;
        if (diff > dmax) dmax = diff;
      end
    end
    check("R9 settled error within 300", (dmax <= 300) ? 1 : 0, 1);
    diff = (longint'(phase_o) - th_in) & MASK;
    if (diff >= 64'h80_0000) diff = diff - 64'h100_0000;
    if (diff < 0) diff = -diff;
    check("R9 phase tracks input", (diff <= 131072) ? 1 : 0, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule